// File: doc/BRIEF.md
# Duplicated Decoder Clock Checker

This block guards a slot decoder that turns a 4-bit slot index into one-hot gated clock enables. It instantiates the functional decoder next to a second, diagnostic decoder of the same kind. Each decoder resolves 16 slot codes, and only the lowest 15 codes drive an enable line. Each decoder takes its own copy of the slot index, so a fault in either index path or in either decoder shows up as a disagreement between the two enable vectors.

The two 15-bit vectors are compared in four equality groups of eight inputs each, which makes four functional/diagnostic pairs per group. The spare sixteenth pair is tied equal. The four group results are ANDed. When that AND falls, a sticky error flag is set on the next rising clock edge. A self-test input forces the flag on, so that the alarm path can be exercised. A separate error-reset input clears it.

Top module: `gdc_checker`

## Requirements
- R1: Each decoder drives enable bit k high exactly when its slot index equals k, for k from 0 to 14. Slot code 15 drives all 15 enables low.
- R2: While `rst_n` is low, `gclk_err` is 0, and it goes to 0 at once without waiting for a clock edge.
- R3: When the two slot indices differ and `err_rst` is low, `gclk_err` is 1 after the next rising edge. It does not change before that edge.
- R4: When the two slot indices are equal, including both at code 15, and `self_test` is low, a cleared `gclk_err` stays 0.
- R5: Once set, `gclk_err` stays 1 after the indices agree again, until `err_rst` or `self_test` acts on it.
- R6: `err_rst` high with `self_test` low clears `gclk_err` at the next rising edge, even when the indices differ in that same cycle.
- R7: `self_test` high sets `gclk_err` at the next rising edge, and it wins over `err_rst` when both are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the error flag is captured on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the error flag |
| func_slot | input | 4 | Slot index feeding the functional decoder |
| diag_slot | input | 4 | Slot index feeding the diagnostic decoder |
| self_test | input | 1 | Forces the error flag on at the next edge |
| err_rst | input | 1 | Clears the error flag at the next edge |
| func_gclk | output | 15 | Functional one-hot gated clock enables |
| diag_gclk | output | 15 | Diagnostic one-hot gated clock enables |
| gclk_err | output | 1 | Sticky decoder mismatch flag |

## Verification
Both enable vectors are combinational, so the bench samples them one time step after it drives the slot indices, with no clock edge in between. The error flag has one register stage. The bench first samples it before the rising edge, to confirm that it has not moved. It then samples it at the falling edge that follows, where a set, clear or forced value is due. All 256 pairs of slot codes are swept this way. Each pair is followed by one agreeing cycle to show that the flag holds, and then by priority cases in which reset, mismatch and self-test arrive in the same cycle.

// File: rtl/gdc_pkg.sv
package gdc_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_SET   = 2'd1,
      ACT_CLEAR = 2'd2,
      ACT_FORCE = 2'd3
   } err_act_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/gdc_slot_decoder.sv
module gdc_slot_decoder #(
   parameter int SLOT_W  = 4,
   parameter int NUM_OUT = 15
) (
   input  logic [SLOT_W-1:0]  slot,
   output logic [NUM_OUT-1:0] onehot
);
   if (NUM_OUT > (1 << SLOT_W)) begin : g_bad_cfg
      $error("gdc_slot_decoder: NUM_OUT exceeds slot code space");
   end

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
      assign onehot[k] = (slot == SLOT_W'(k));
   end
endmodule

// File: rtl/gdc_pair_group.sv
module gdc_pair_group #(
   parameter int PAIRS = 4
) (
   input  logic [PAIRS-1:0] side_a,
   input  logic [PAIRS-1:0] side_b,
   output logic             equal
);
   if (PAIRS < 1) begin : g_bad_cfg
      $error("gdc_pair_group: PAIRS must be at least 1");
   end

   assign equal = (side_a == side_b);
endmodule

// File: rtl/gdc_err_reg.sv
module gdc_err_reg
   import gdc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic all_eq,
   input  logic self_test,
   input  logic err_rst,
   output logic err
);
   err_act_e act;

   always_comb begin
      act = ACT_HOLD;
      if (self_test)    act = ACT_FORCE;
      else if (err_rst) act = ACT_CLEAR;
      else if (!all_eq) act = ACT_SET;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err <= 1'b0;
      end else begin
         case (act)
            ACT_FORCE, ACT_SET: err <= 1'b1;
            ACT_CLEAR:          err <= 1'b0;
            default:            err <= err;
         endcase
      end
   end

   // R3
   mismatch_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!all_eq && !err_rst) |=> err);
   // R7
   force_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      self_test |=> err);
   // R6
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_rst && !self_test) |=> !err);
   // R5
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !err_rst) |=> err);
   // R4
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!err && all_eq && !self_test) |=> !err);
endmodule

// File: rtl/gdc_checker.sv
module gdc_checker
   import gdc_pkg::*;
#(
   parameter int SLOT_W   = 4,
   parameter int NUM_GCLK = 15,
   parameter int GRP_PAIRS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SLOT_W-1:0]   func_slot,
   input  logic [SLOT_W-1:0]   diag_slot,
   input  logic                self_test,
   input  logic                err_rst,
   output logic [NUM_GCLK-1:0] func_gclk,
   output logic [NUM_GCLK-1:0] diag_gclk,
   output logic                gclk_err
);
   localparam int NUM_GRP = ceil_div(NUM_GCLK, GRP_PAIRS);
   localparam int PAD_W   = NUM_GRP * GRP_PAIRS;

   if (NUM_GCLK < 1 || NUM_GCLK > (1 << SLOT_W)) begin : g_bad_cfg
      $error("gdc_checker: NUM_GCLK outside slot code space");
   end

   gdc_slot_decoder #(.SLOT_W(SLOT_W), .NUM_OUT(NUM_GCLK)) u_func_dec (
      .slot   (func_slot),
      .onehot (func_gclk)
   );

   gdc_slot_decoder #(.SLOT_W(SLOT_W), .NUM_OUT(NUM_GCLK)) u_diag_dec (
      .slot   (diag_slot),
      .onehot (diag_gclk)
   );

   logic [PAD_W-1:0]   func_pad;
   logic [PAD_W-1:0]   diag_pad;
   logic [NUM_GRP-1:0] grp_eq;
   logic               all_eq;

   if (PAD_W > NUM_GCLK) begin : g_pad
      assign func_pad = {{(PAD_W-NUM_GCLK){1'b0}}, func_gclk};
      assign diag_pad = {{(PAD_W-NUM_GCLK){1'b0}}, diag_gclk};
   end else begin : g_nopad
      assign func_pad = func_gclk;
      assign diag_pad = diag_gclk;
   end

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      gdc_pair_group #(.PAIRS(GRP_PAIRS)) u_grp (
         .side_a (func_pad[g*GRP_PAIRS +: GRP_PAIRS]),
         .side_b (diag_pad[g*GRP_PAIRS +: GRP_PAIRS]),
         .equal  (grp_eq[g])
      );
   end

   assign all_eq = &grp_eq;

   gdc_err_reg u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .all_eq    (all_eq),
      .self_test (self_test),
      .err_rst   (err_rst),
      .err       (gclk_err)
   );

   // R1
   func_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(func_gclk));
   // R1
   diag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(diag_gclk));
   // R1
   idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(func_slot) >= NUM_GCLK) |-> (func_gclk == '0));
   // R3
   slot_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((func_slot != diag_slot) && !err_rst) |=> gclk_err);
endmodule

// File: tb/gdc_checker_tb.sv
module gdc_checker_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  func_slot = '0;
   logic [3:0]  diag_slot = '0;
   logic        self_test = 1'b0;
   logic        err_rst = 1'b0;
   logic [14:0] func_gclk;
   logic [14:0] diag_gclk;
   logic        gclk_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gdc_checker u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .func_slot (func_slot),
      .diag_slot (diag_slot),
      .self_test (self_test),
      .err_rst   (err_rst),
      .func_gclk (func_gclk),
      .diag_gclk (diag_gclk),
      .gclk_err  (gclk_err)
   );

   function automatic logic [14:0] exp_dec(input logic [3:0] s);
      return (s < 4'd15) ? (15'd1 << s) : 15'd0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // clear the flag through a one-cycle reset pulse with agreeing slots
   task automatic clear_flag();
      @(negedge clk);
      func_slot = 4'd0; diag_slot = 4'd0; self_test = 1'b0; err_rst = 1'b1;
      @(negedge clk);
      err_rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R2 reset state
      #2;
      chk("R2 reset", 32'(gclk_err), 32'd0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 after release", 32'(gclk_err), 32'd0);

      // sweep of all slot pairs: R1, R3, R4, R5
      for (int f = 0; f < 16; f++) begin
         for (int d = 0; d < 16; d++) begin
            clear_flag();
            chk("R6 cleared", 32'(gclk_err), 32'd0);
            func_slot = 4'(f); diag_slot = 4'(d);
            #1;
            chk("R1 func", 32'(func_gclk), 32'(exp_dec(4'(f))));
            chk("R1 diag", 32'(diag_gclk), 32'(exp_dec(4'(d))));
            chk("R3 no early", 32'(gclk_err), 32'd0);
            @(negedge clk);
            chk((f != d) ? "R3 set" : "R4 quiet", 32'(gclk_err), 32'(f != d));
            func_slot = 4'(d);
            @(negedge clk);
            chk("R5 hold", 32'(gclk_err), 32'(f != d));
         end
      end

      // R6 reset wins over mismatch
      clear_flag();
      func_slot = 4'd2; diag_slot = 4'd9;
      @(negedge clk);
      chk("R3 set pre", 32'(gclk_err), 32'd1);
      err_rst = 1'b1;
      @(negedge clk);
      chk("R6 clear over mismatch", 32'(gclk_err), 32'd0);
      err_rst = 1'b0;
      func_slot = 4'd9;
      @(negedge clk);
      chk("R4 stays clear", 32'(gclk_err), 32'd0);

      // R7 self-test alone, and over reset
      self_test = 1'b1;
      #1;
      chk("R7 no early", 32'(gclk_err), 32'd0);
      @(negedge clk);
      chk("R7 force", 32'(gclk_err), 32'd1);
      self_test = 1'b0;
      @(negedge clk);
      chk("R5 hold after force", 32'(gclk_err), 32'd1);
      clear_flag();
      chk("R6 cleared", 32'(gclk_err), 32'd0);
      self_test = 1'b1; err_rst = 1'b1;
      @(negedge clk);
      chk("R7 beats reset", 32'(gclk_err), 32'd1);
      self_test = 1'b0; err_rst = 1'b0;

      // R2 asynchronous reset mid-run
      #2;
      rst_n = 1'b0;
      #1;
      chk("R2 async clear", 32'(gclk_err), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 stays clear", 32'(gclk_err), 32'd0);

      finish_run();
   end
endmodule